// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts the next fetch address in the same cycle that an instruction address is fetched. It is built as a direct-mapped table. Each row holds a valid flag, an address tag, a predicted target address and a single taken/not-taken bit. The fetch address selects a row. If the tag matches and the direction bit says taken, the stored target becomes the next fetch address. In every other case the next address is the fetch address plus four. The lookup is combinational from registered table contents, so a prediction is available every cycle and fetch never waits for it.

A feedback port carries resolved branches back from the execution backend: the branch address, its real target and whether it was taken. A taken branch that has no row installs one with its direction bit set. A branch that already has a row gets its direction bit overwritten with the outcome, and also gets its target overwritten when the outcome is taken. A branch that was correctly predicted not taken and has no row leaves the table alone. A feedback write becomes visible at the next clock edge, so a lookup of the same row in the same cycle still reads the old contents.

The row index is address bits [IDX_W+1:2]. The tag is made of the remaining upper address bits together with address bits [1:0], so a misaligned address never matches an aligned row. The asynchronous active-low reset is synchronized on release inside the block and clears every valid flag.

Top module: `btb_predictor`

## Requirements
- R1: While reset is held, and after reset is released with no feedback yet received, every lookup reports a miss (`pred_hit`=0, `pred_taken`=0, `pred_next_pc`=`fetch_pc`+4). A branch looked up for the first time is therefore predicted not taken.
- R2: A lookup whose row is valid, whose tag matches and whose direction bit is 1 drives `pred_hit`=1, `pred_taken`=1, and `pred_next_pc` equal to the stored target.
- R3: A lookup whose row is valid and whose tag matches, but whose direction bit is 0, drives `pred_hit`=1, `pred_taken`=0, and `pred_next_pc`=`fetch_pc`+4.
- R4: Taken feedback for an address with no matching row installs a row with that tag, the reported target and the direction bit set to 1. The next lookup of that address predicts taken to that target.
- R5: Not-taken feedback for an address with no matching row changes nothing. A later lookup of that address still misses.
- R6: Not-taken feedback for an address with a matching row clears its direction bit and keeps the row valid. The next lookup reports a hit that is predicted not taken.
- R7: Taken feedback for an address with a matching row sets its direction bit to 1 and replaces the stored target with the reported one.
- R8: The row index is `pc[IDX_W+1:2]` (bits [5:2] by default). Two addresses with the same index but different upper bits do not match each other. Taken feedback for one of them evicts the other's row.
- R9: When feedback and a lookup touch the same row in one cycle, the lookup returns the contents from before that cycle. The update becomes visible in the cycle after the clock edge.
- R10: `pred_next_pc` is computed in PC_W-bit arithmetic, so a miss at the last word address wraps to 0.
- R11: While `fb_valid` is 0, the feedback address, target and outcome inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally on release |
| fetch_pc | input | PC_W | Address currently being fetched |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_taken | output | 1 | 1 when the prediction is a taken branch |
| pred_hit | output | 1 | 1 when the fetch address matched a valid row |
| fb_valid | input | 1 | Qualifies the feedback inputs for this cycle |
| fb_pc | input | PC_W | Address of the resolved branch |
| fb_target | input | PC_W | Actual target of the resolved branch |
| fb_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
The bench uses the default parameters, PC_W=32 and IDX_W=4. With 16 rows, addresses 0x114 and 0x154 share row 5 and differ only in their tag, which makes the conflict and eviction case reachable with small constants. The 32-bit width puts the wrap of address 0xFFFFFFFC to zero within reach. Row 15 is reached with 0x3C and row 0 with 0x3C0, so both ends of the index range are exercised.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Kind of table write selected by resolved-branch feedback
  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_ALLOC    = 2'd1,
    UPD_STATE    = 2'd2,
    UPD_RETARGET = 2'd3
  } upd_kind_e;

  localparam int unsigned WORD_OFS_W = 2;

endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W   = PC_W - IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic             rd_st,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  // feedback read port
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_vld,
  output logic [TAG_W-1:0] up_tag,
  // write port
  input  logic             wr_en,
  input  logic             wr_load_tgt,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic             wr_state
);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] st_q,  st_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ENTRIES-1:0] row_ld;

  // next state for the control bits
  always_comb begin
    vld_d = vld_q;
    st_d  = st_q;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      st_d[wr_idx]  = wr_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      st_q  <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
    end
  end

  // tag and target storage: no reset, row-wise load enables
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
      assign row_ld[g] = wr_en && wr_load_tgt && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (row_ld[g]) begin
          tag_q[g] <= wr_tag;
          tgt_q[g] <= wr_tgt;
        end
      end
    end
  endgenerate

  assign rd_vld = vld_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_tgt = tgt_q[rd_idx];
  assign up_vld = vld_q[up_idx];
  assign up_tag = tag_q[up_idx];

  // R4: a write with the direction bit set leaves the row valid and predicting taken
  assert_alloc_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state) |=> (vld_q[$past(wr_idx)] && st_q[$past(wr_idx)]));

  // R6: a not-taken write clears the direction bit but keeps the row
  assert_nt_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_state) |=> (vld_q[$past(wr_idx)] && !st_q[$past(wr_idx)]));

  // R9: with no write the control bits hold
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vld_q) && $stable(st_q)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_vld,
  input  logic             rd_st,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_tgt,
  output logic [PC_W-1:0]  pred_next_pc,
  output logic             pred_taken,
  output logic             pred_hit
);

  import btb_pkg::*;

  logic [TAG_W-1:0] fetch_tag;
  logic [PC_W-1:0]  seq_pc;

  assign rd_idx    = fetch_pc[IDX_W+WORD_OFS_W-1:WORD_OFS_W];
  assign fetch_tag = {fetch_pc[PC_W-1:IDX_W+WORD_OFS_W], fetch_pc[WORD_OFS_W-1:0]};
  assign seq_pc    = fetch_pc + PC_W'(4);

  always_comb begin
    pred_hit     = rd_vld && (rd_tag == fetch_tag);
    pred_taken   = pred_hit && rd_st;
    pred_next_pc = pred_taken ? rd_tgt : seq_pc;
  end

  // R2: a taken prediction always comes from a matching valid row
  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (pred_hit && rd_vld));

  // R3: a hit with a clear direction bit falls through
  assert_hit_nt_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && !rd_st) |-> (pred_next_pc == fetch_pc + PC_W'(4)));

endmodule

// File: rtl/btb_update.sv
module btb_update #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_valid,
  input  logic [PC_W-1:0]  fb_pc,
  input  logic [PC_W-1:0]  fb_target,
  input  logic             fb_taken,
  output logic [IDX_W-1:0] up_idx,
  input  logic             up_vld,
  input  logic [TAG_W-1:0] up_tag,
  output logic             wr_en,
  output logic             wr_load_tgt,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output logic             wr_state
);

  import btb_pkg::*;

  upd_kind_e  kind;
  logic [TAG_W-1:0] fb_tag;
  logic       fb_hit;

  assign up_idx = fb_pc[IDX_W+WORD_OFS_W-1:WORD_OFS_W];
  assign fb_tag = {fb_pc[PC_W-1:IDX_W+WORD_OFS_W], fb_pc[WORD_OFS_W-1:0]};
  assign fb_hit = up_vld && (up_tag == fb_tag);

  always_comb begin
    kind = UPD_NONE;
    if (fb_valid) begin
      if (fb_hit) begin
        kind = fb_taken ? UPD_RETARGET : UPD_STATE;
      end else if (fb_taken) begin
        kind = UPD_ALLOC;
      end
    end
  end

  assign wr_en       = (kind != UPD_NONE);
  assign wr_load_tgt = (kind == UPD_ALLOC) || (kind == UPD_RETARGET);
  assign wr_idx      = up_idx;
  assign wr_tag      = fb_tag;
  assign wr_tgt      = fb_target;
  assign wr_state    = fb_taken;

  // R5: correct not-taken with no row never writes
  assert_nt_miss_noalloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && !fb_taken && !fb_hit) |-> !wr_en);

  // R11: an idle feedback port never writes
  assert_idle_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_valid |-> !wr_en);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_taken,
  output logic            pred_hit,
  input  logic            fb_valid,
  input  logic [PC_W-1:0] fb_pc,
  input  logic [PC_W-1:0] fb_target,
  input  logic            fb_taken
);

  localparam int unsigned TAG_W = PC_W - IDX_W;

  logic             rst_sync_n;
  logic [IDX_W-1:0] rd_idx, up_idx, wr_idx;
  logic             rd_vld, rd_st, up_vld;
  logic [TAG_W-1:0] rd_tag, up_tag, wr_tag;
  logic [PC_W-1:0]  rd_tgt, wr_tgt;
  logic             wr_en, wr_load_tgt, wr_state;

  btb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fetch_pc     (fetch_pc),
    .rd_idx       (rd_idx),
    .rd_vld       (rd_vld),
    .rd_st        (rd_st),
    .rd_tag       (rd_tag),
    .rd_tgt       (rd_tgt),
    .pred_next_pc (pred_next_pc),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit)
  );

  btb_update #(.PC_W(PC_W), .IDX_W(IDX_W)) u_update (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fb_valid    (fb_valid),
    .fb_pc       (fb_pc),
    .fb_target   (fb_target),
    .fb_taken    (fb_taken),
    .up_idx      (up_idx),
    .up_vld      (up_vld),
    .up_tag      (up_tag),
    .wr_en       (wr_en),
    .wr_load_tgt (wr_load_tgt),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .wr_tgt      (wr_tgt),
    .wr_state    (wr_state)
  );

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_idx      (rd_idx),
    .rd_vld      (rd_vld),
    .rd_st       (rd_st),
    .rd_tag      (rd_tag),
    .rd_tgt      (rd_tgt),
    .up_idx      (up_idx),
    .up_vld      (up_vld),
    .up_tag      (up_tag),
    .wr_en       (wr_en),
    .wr_load_tgt (wr_load_tgt),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .wr_tgt      (wr_tgt),
    .wr_state    (wr_state)
  );

  // R1: while the synchronized reset is low nothing can hit
  assert_reset_miss_R1: assert property (@(posedge clk)
    (rst_n && !rst_sync_n) |-> (!pred_hit && !pred_taken));

endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;

  localparam int PC_W = 32;

  typedef struct packed {
    logic        fbv;
    logic [31:0] fbpc;
    logic [31:0] fbtgt;
    logic        fbtk;
    logic [31:0] fpc;
    logic [31:0] enext;
    logic        etk;
    logic        ehit;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  // per step: feedback and fetch applied together; outputs checked before the edge
  localparam vec_t VEC [0:NVEC-1] = '{
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h118, 1'b0, 1'b0, 8'd1},  // R1 first fetch
    '{1'b1, 32'h114, 32'h100, 1'b0, 32'h114,      32'h118, 1'b0, 1'b0, 8'd5},  // R5 nt, no row
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h118, 1'b0, 1'b0, 8'd5},  // R5 still miss
    '{1'b1, 32'h114, 32'h100, 1'b1, 32'h114,      32'h118, 1'b0, 1'b0, 8'd9},  // R9 old view
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h100, 1'b1, 1'b1, 8'd4},  // R4 installed
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h118,      32'h11C, 1'b0, 1'b0, 8'd2},  // R2 neighbour miss
    '{1'b1, 32'h114, 32'h0,   1'b0, 32'h114,      32'h100, 1'b1, 1'b1, 8'd9},  // R9 old view
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h118, 1'b0, 1'b1, 8'd6},  // R6 cleared
    '{1'b1, 32'h114, 32'h200, 1'b1, 32'h114,      32'h118, 1'b0, 1'b1, 8'd3},  // R3 hit nt
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h200, 1'b1, 1'b1, 8'd7},  // R7 retarget
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h154,      32'h158, 1'b0, 1'b0, 8'd8},  // R8 tag differs
    '{1'b1, 32'h154, 32'h300, 1'b1, 32'h154,      32'h158, 1'b0, 1'b0, 8'd8},  // R8 evicting write
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h154,      32'h300, 1'b1, 1'b1, 8'd8},  // R8 new owner
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h114,      32'h118, 1'b0, 1'b0, 8'd8},  // R8 old evicted
    '{1'b1, 32'h3C,  32'h10,  1'b1, 32'h3C,       32'h40,  1'b0, 1'b0, 8'd4},  // R4 row 15
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h3C,       32'h10,  1'b1, 1'b1, 8'd2},  // R2 row 15
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'h3E,       32'h42,  1'b0, 1'b0, 8'd8},  // R8 misaligned no match
    '{1'b0, 32'h0,   32'h0,   1'b0, 32'hFFFFFFFC, 32'h0,   1'b0, 1'b0, 8'd10}  // R10 wrap
  };

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] fetch_pc;
  logic [PC_W-1:0] pred_next_pc;
  logic            pred_taken;
  logic            pred_hit;
  logic            fb_valid;
  logic [PC_W-1:0] fb_pc;
  logic [PC_W-1:0] fb_target;
  logic            fb_taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  btb_predictor #(.PC_W(PC_W), .IDX_W(4)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit),
    .fb_valid     (fb_valid),
    .fb_pc        (fb_pc),
    .fb_target    (fb_target),
    .fb_taken     (fb_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input int req, input logic [31:0] en, input logic et, input logic eh);
    n_checks++;
    if (pred_next_pc !== en || pred_taken !== et || pred_hit !== eh) begin
      n_fail++;
      $display("FAIL R%0d pc=%h: next=%h taken=%b hit=%b expected next=%h taken=%b hit=%b",
               req, fetch_pc, pred_next_pc, pred_taken, pred_hit, en, et, eh);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] p, input logic [31:0] t,
                       input logic k, input logic [31:0] f);
    @(negedge clk);
    fb_valid  = v;
    fb_pc     = p;
    fb_target = t;
    fb_taken  = k;
    fetch_pc  = f;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fb_valid = 1'b0;
    #1;
    // R1: lookups miss while reset is held
    check(1, fetch_pc + 32'd4, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; fetch_pc = 32'h154; fb_valid = 1'b0;
    fb_pc = '0; fb_target = '0; fb_taken = 1'b0;
    do_reset();

    // R1: empty table after reset, several addresses
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0);     check(1, 32'h4,   1'b0, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h3C0);   check(1, 32'h3C4, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].fbv, VEC[i].fbpc, VEC[i].fbtgt, VEC[i].fbtk, VEC[i].fpc);
      check(int'(VEC[i].req), VEC[i].enext, VEC[i].etk, VEC[i].ehit);
    end

    // R11: feedback inputs with fb_valid low leave row 0 empty
    drive(1'b0, 32'h3C0, 32'h40, 1'b1, 32'h3C0);
    check(11, 32'h3C4, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h3C0);
    check(11, 32'h3C4, 1'b0, 1'b0);

    // R4: row 0 then installs normally
    drive(1'b1, 32'h3C0, 32'h40, 1'b1, 32'h3C0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h3C0);
    check(4, 32'h40, 1'b1, 1'b1);

    // R1: reset mid-run clears every row
    do_reset();
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h154);   check(1, 32'h158, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h3C);    check(1, 32'h40,  1'b0, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h3C0);   check(1, 32'h3C4, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule